// File: doc/BRIEF.md
# Condition Register Move Unit

This block executes the two data-movement operations that touch a 32-bit condition register built from eight 4-bit fields. A move-to operation loads chosen fields from a 64-bit source operand. A move-from operation returns the condition register as a 64-bit result. The result is either a full copy or a copy filtered field by field. An 8-bit field mask carried in the instruction word selects which fields take part. One further instruction bit picks between the filtered and the full move-from copy.

The unit has a single registered stage. The operation code, instruction word, operand and current condition register are sampled on a rising clock edge. The updated condition register and the result then appear on the outputs until the next edge. Any operation code that is not a move leaves the register untouched and returns a zero result.

Top module: `cru_top`

## Requirements
- R1: The field mask is instruction bits 19..12. Mask bit i (instruction bit 12+i) governs condition field i. Field i occupies bits 4i+3..4i of the condition register, the operand and the result. No other instruction bit except bit 20 changes any output.
- R2: For op_i = 2'b01 (move-to), every field whose mask bit is 1 takes operand bits 4i+3..4i in cr_o.
- R3: For a move-to, every field whose mask bit is 0 keeps its value from cr_i.
- R4: For a move-to, res_o is zero.
- R5: For op_i = 2'b10 (move-from) with instruction bit 20 = 1, result field i equals condition field i where the mask bit is 1, and is zero where the mask bit is 0.
- R6: For a move-from with instruction bit 20 = 0, res_o[31:0] equals cr_i whatever the mask is.
- R7: res_o[63:32] is always zero, and operand bits 63..32 never change any output.
- R8: For a move-from, cr_o equals cr_i.
- R9: For op_i = 2'b00 or 2'b11 (idle), cr_o equals cr_i and res_o is zero.
- R10: Outputs are registered. Inputs sampled on one rising edge show on cr_o/res_o after that edge. While rst_n is low, both outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 2 | Operation code: 00 idle, 01 move-to, 10 move-from, 11 idle |
| insn_i | input | 32 | Instruction word (mask at 19..12, select at 20) |
| opnd_i | input | 64 | Source operand for move-to |
| cr_i | input | 32 | Current condition register |
| cr_o | output | 32 | Updated condition register |
| res_o | output | 64 | Move-from result |

## Verification
The assertions compare each output with the inputs sampled one edge earlier. They hold only from the second edge after reset is released, which a liveness flop tracks. So they assume that inputs are valid, with no X or Z, on every edge outside reset. The bench drives every input on the falling edge with defined values, and random bits fill the unused instruction and operand positions. It sweeps all 256 masks under both select values and every operation code. This keeps the stimulus inside that assumption while covering every field combination.

// File: rtl/cru_pkg.sv
package cru_pkg;
  parameter int FIELD_W   = 4;
  parameter int N_FIELDS  = 8;
  parameter int OPND_W    = 64;
  parameter int INSN_W    = 32;
  parameter int MASK_LSB  = 12;
  parameter int SEL_BIT   = 20;

  localparam int CR_W  = FIELD_W * N_FIELDS;
  localparam int HI_W  = OPND_W - CR_W;

  typedef enum logic [1:0] {
    OP_IDLE0 = 2'b00,
    OP_TO    = 2'b01,
    OP_FROM  = 2'b10,
    OP_IDLE1 = 2'b11
  } cru_op_e;

  // Widen a per-field mask into a per-bit mask.
  function automatic logic [CR_W-1:0] cru_expand(input logic [N_FIELDS-1:0] m);
    logic [CR_W-1:0] r;
    r = '0;
    for (int f = 0; f < N_FIELDS; f++) begin
      r[f*FIELD_W +: FIELD_W] = {FIELD_W{m[f]}};
    end
    return r;
  endfunction

  // Merge source into base wherever the bit mask is set.
  function automatic logic [CR_W-1:0] cru_merge(input logic [CR_W-1:0] base,
                                                input logic [CR_W-1:0] src,
                                                input logic [CR_W-1:0] bm);
    return (base & ~bm) | (src & bm);
  endfunction
endpackage

// File: rtl/cru_decode.sv
module cru_decode
  import cru_pkg::*;
(
  input  logic [INSN_W-1:0]   insn_i,
  input  logic [1:0]          op_i,
  output logic [N_FIELDS-1:0] mask_o,
  output logic                sel_mask_o,
  output logic                is_to_o,
  output logic                is_from_o
);
  cru_op_e op;
  logic [INSN_W-1:0] unused_insn_bits;

  assign op         = cru_op_e'(op_i);
  assign mask_o     = insn_i[MASK_LSB +: N_FIELDS];
  assign sel_mask_o = insn_i[SEL_BIT];
  assign is_to_o    = (op == OP_TO);
  assign is_from_o  = (op == OP_FROM);
  assign unused_insn_bits = insn_i;
endmodule

// File: rtl/cru_move_to.sv
module cru_move_to
  import cru_pkg::*;
(
  input  logic                en_i,
  input  logic [N_FIELDS-1:0] mask_i,
  input  logic [CR_W-1:0]     src_i,
  input  logic [CR_W-1:0]     cr_i,
  output logic [N_FIELDS-1:0] wr_en_o,
  output logic [CR_W-1:0]     cr_o
);
  logic [CR_W-1:0] bit_mask;

  for (genvar g = 0; g < N_FIELDS; g++) begin : g_fld
    assign wr_en_o[g] = en_i & mask_i[g];
  end

  assign bit_mask = cru_expand(wr_en_o);
  assign cr_o     = cru_merge(cr_i, src_i, bit_mask);
endmodule

// File: rtl/cru_move_from.sv
module cru_move_from
  import cru_pkg::*;
(
  input  logic                en_i,
  input  logic                sel_mask_i,
  input  logic [N_FIELDS-1:0] mask_i,
  input  logic [CR_W-1:0]     cr_i,
  output logic [OPND_W-1:0]   res_o
);
  logic [N_FIELDS-1:0] keep;
  logic [CR_W-1:0]     low;

  for (genvar g = 0; g < N_FIELDS; g++) begin : g_fld
    assign keep[g] = en_i & (~sel_mask_i | mask_i[g]);
    assign low[g*FIELD_W +: FIELD_W] = keep[g] ? cr_i[g*FIELD_W +: FIELD_W] : '0;
  end

  assign res_o = {{HI_W{1'b0}}, low};
endmodule

// File: rtl/cru_top.sv
module cru_top
  import cru_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        op_i,
  input  logic [31:0]       insn_i,
  input  logic [63:0]       opnd_i,
  input  logic [31:0]       cr_i,
  output logic [31:0]       cr_o,
  output logic [63:0]       res_o
);
  logic [N_FIELDS-1:0] mask_w;
  logic                sel_mask_w;
  logic                is_to_w;
  logic                is_from_w;
  logic [N_FIELDS-1:0] fld_wr_w;
  logic [CR_W-1:0]     cr_next_w;
  logic [OPND_W-1:0]   res_next_w;
  logic [HI_W-1:0]     unused_opnd_hi;
  logic                live_q;

  assign unused_opnd_hi = opnd_i[OPND_W-1:CR_W];

  cru_decode u_dec (
    .insn_i     (insn_i),
    .op_i       (op_i),
    .mask_o     (mask_w),
    .sel_mask_o (sel_mask_w),
    .is_to_o    (is_to_w),
    .is_from_o  (is_from_w)
  );

  cru_move_to u_to (
    .en_i    (is_to_w),
    .mask_i  (mask_w),
    .src_i   (opnd_i[CR_W-1:0]),
    .cr_i    (cr_i),
    .wr_en_o (fld_wr_w),
    .cr_o    (cr_next_w)
  );

  cru_move_from u_from (
    .en_i       (is_from_w),
    .sel_mask_i (sel_mask_w),
    .mask_i     (mask_w),
    .cr_i       (cr_i),
    .res_o      (res_next_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cr_o   <= '0;
      res_o  <= '0;
      live_q <= 1'b0;
    end else begin
      cr_o   <= cr_next_w;
      res_o  <= res_next_w;
      live_q <= 1'b1;
    end
  end

  // R4
  to_res_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live_q && $past(is_to_w) |-> res_o == '0);

  // R7
  res_high_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_o[63:32] == '0);

  // R8
  from_cr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live_q && $past(is_from_w) |-> cr_o == $past(cr_i));

  // R6
  from_full_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live_q && $past(is_from_w && !sel_mask_w) |-> res_o[31:0] == $past(cr_i));

  // R9
  idle_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live_q && $past(!is_to_w && !is_from_w) |-> (cr_o == $past(cr_i)) && (res_o == '0));

  // R1
  wr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !is_to_w |-> fld_wr_w == '0);

  for (genvar g = 0; g < N_FIELDS; g++) begin : g_chk
    // R2
    to_field_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      live_q && $past(fld_wr_w[g]) |->
        cr_o[g*FIELD_W +: FIELD_W] == $past(opnd_i[g*FIELD_W +: FIELD_W]));
    // R3
    to_field_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      live_q && $past(is_to_w && !mask_w[g]) |->
        cr_o[g*FIELD_W +: FIELD_W] == $past(cr_i[g*FIELD_W +: FIELD_W]));
    // R5
    from_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      live_q && $past(is_from_w && sel_mask_w) |->
        res_o[g*FIELD_W +: FIELD_W] ==
          ($past(mask_w[g]) ? $past(cr_i[g*FIELD_W +: FIELD_W]) : 4'h0));
  end
endmodule

// File: tb/cru_top_tb.sv
`timescale 1ns/1ps
module cru_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  op_i = 2'b00;
  logic [31:0] insn_i = '0;
  logic [63:0] opnd_i = '0;
  logic [31:0] cr_i = '0;
  logic [31:0] cr_o;
  logic [63:0] res_o;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cru_top u_dut (.clk(clk), .rst_n(rst_n), .op_i(op_i), .insn_i(insn_i),
                 .opnd_i(opnd_i), .cr_i(cr_i), .cr_o(cr_o), .res_o(res_o));

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drive on a falling edge, let one rising edge capture, sample on the next falling edge.
  task automatic apply(input logic [1:0] op, input logic [31:0] insn,
                       input logic [63:0] opnd, input logic [31:0] cr);
    @(negedge clk);
    op_i = op; insn_i = insn; opnd_i = opnd; cr_i = cr;
    @(negedge clk);
  endtask

  function automatic logic [31:0] exp_cr(input logic [1:0] op, input logic [7:0] m,
                                         input logic [63:0] opnd, input logic [31:0] cr);
    logic [31:0] r = cr;
    if (op == 2'b01)
      for (int i = 0; i < 8; i++)
        if ((m >> i) & 8'd1) r = (r & ~(32'hF << (4*i))) | (opnd[31:0] & (32'hF << (4*i)));
    return r;
  endfunction

  function automatic logic [63:0] exp_res(input logic [1:0] op, input logic [7:0] m,
                                          input logic sel, input logic [31:0] cr);
    logic [31:0] r = 32'h0;
    if (op == 2'b10) begin
      if (!sel) r = cr;
      else for (int i = 0; i < 8; i++)
        if ((m >> i) & 8'd1) r = r | (cr & (32'hF << (4*i)));
    end
    return {32'h0, r};
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    op_i = 2'b01; insn_i = 32'h000F_F000; opnd_i = '1; cr_i = 32'h1234_5678;
    repeat (3) @(negedge clk);
    check("R10 reset cr_o", {32'h0, cr_o}, 64'h0);
    check("R10 reset res_o", res_o, 64'h0);
    rst_n = 1'b1;
    // Sweep every mask under every op and both select values.
    for (int op = 0; op < 4; op++) begin
      for (int s = 0; s < 2; s++) begin
        for (int m = 0; m < 256; m++) begin
          logic [31:0] insn, cr;
          logic [63:0] opnd;
          insn = $urandom;
          insn[19:12] = m[7:0];
          insn[20] = s[0];
          opnd = {$urandom, $urandom};
          cr = $urandom;
          apply(op[1:0], insn, opnd, cr);
          if (op == 1) begin
            check("R1 R2 R3 move-to cr_o", {32'h0, cr_o}, {32'h0, exp_cr(2'b01, m[7:0], opnd, cr)});
            check("R4 move-to res_o", res_o, 64'h0);
          end else if (op == 2) begin
            check("R8 move-from cr_o", {32'h0, cr_o}, {32'h0, cr});
            check(s ? "R5 masked move-from res_o" : "R6 full move-from res_o",
                  res_o, exp_res(2'b10, m[7:0], s[0], cr));
          end else begin
            check("R9 idle cr_o", {32'h0, cr_o}, {32'h0, cr});
            check("R9 idle res_o", res_o, 64'h0);
          end
          check("R7 res_o high zero", {32'h0, res_o[63:32]}, 64'h0);
        end
      end
    end
    // R7: operand high half is ignored by a full-mask move-to.
    apply(2'b01, 32'h000F_F000, 64'hFFFF_FFFF_0000_0000, 32'hA5A5_A5A5);
    check("R7 opnd high ignored", {32'h0, cr_o}, 64'h0);
    // R1: bits outside 20..12 do not matter.
    apply(2'b10, 32'hFFE0_0FFF | (32'h1 << 20) | (32'h0F << 12), 64'h0, 32'hDEAD_BEEF);
    check("R1 R5 low-field mask", res_o, 64'h0000_0000_0000_BEEF);
    // R10: reset mid-run clears outputs.
    apply(2'b10, 32'h0, 64'h0, 32'hCAFE_F00D);
    check("R10 latency one edge", res_o, 64'h0000_0000_CAFE_F00D);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R10 reset clears res_o", res_o, 64'h0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule